// File: doc/BRIEF.md
# SDRAM Single-Bank Command Legality Monitor

This block sits passively on an SDRAM command bus and follows the life of one bank. Each clock it turns the active-low select, row-strobe, column-strobe and write-enable pins into a command code. It applies the command to the bank it tracks, and it raises a one-cycle flag when the command is not allowed in the bank's present state. The checked states are write recovery, write recovery ending in auto precharge, refresh and mode-register access. Idle, row active and precharge are followed so that the checked states can be entered and left correctly, but commands in those three states are never flagged.

Each timed state has a down-counter that is loaded with its own cycle parameter on entry, so the bank leaves that state on its own at the right edge. A command only takes part when clock enable was high on the previous edge. It must also address this bank, or be one that reaches every bank: refresh, mode-register set, or precharge with A10 high. Typical uses are a protocol monitor in a simulation environment or a run-time checker beside a memory controller.

Top module: `sdram_bank_checker`

## Requirements
- R1: The command code on `cmd_o` follows the edge at which the pins were sampled. With the pins in the order select, row, column, write (0 = low): select high gives 0 (deselect); 0111 gives 1 (no-op); 0110 gives 2 (burst stop); 0101 gives 3 (read); 0100 gives 4 (write); 0011 gives 5 (activate); 0010 gives 6 (precharge); 0001 gives 7 (refresh); 0000 gives 8 (mode-register set).
- R2: In write recovery (state code 2), deselect, no-op and burst stop are not flagged. Exactly T_DPL edges after entry the bank moves to row active (code 1).
- R3: In write recovery, read and write are accepted. A write re-enters recovery: code 2 when A10 is low, code 3 when A10 is high. A read goes to row active when A10 is low, and to precharge (code 4) when A10 is high. Activate, precharge, refresh and mode-register set are flagged.
- R4: In recovery with auto precharge (code 3), deselect, no-op and burst stop are not flagged, while read, write, activate, precharge, refresh and mode-register set are flagged. Exactly T_DPL edges after entry the bank moves to precharge (code 4).
- R5: In refresh (code 5), only deselect, no-op and burst stop pass, and every other command is flagged. Exactly T_RC edges after entry the bank returns to idle (code 0).
- R6: In mode-register access (code 6), only deselect and no-op pass, and burst stop and every other command are flagged. Exactly T_RSC edges after entry the bank returns to idle.
- R7: A command sampled while clock enable was low on the previous edge is ignored. It raises no flag and causes no transition, but the timers keep counting.
- R8: A command whose bank address differs from BANK_ID is ignored. Refresh, mode-register set and precharge with A10 high are exceptions and apply to this bank whatever the bank address.
- R9: `illegal_o` is registered and lasts exactly one cycle for each offending command. `cmd_o` shows that same command in that cycle. An offending command never changes the state; only the state's own timer can move it.
- R10: Synchronous active-high reset gives state code 0, `illegal_o` low and all counters cleared.
- R11: From idle: activate goes to row active, refresh goes to refresh, and mode-register set goes to mode-register access. From row active: write goes to code 2 or 3 according to A10, and precharge goes to code 4. Precharge returns to idle exactly T_RP edges after entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Address bit 10: auto-precharge / all-bank qualifier |
| cke | input | 1 | Clock enable |
| state_o | output | 3 | Tracked bank state code |
| illegal_o | output | 1 | One-cycle flag for an illegal command |
| cmd_o | output | 4 | Code of the command sampled at the last edge |

## Verification
The bench runs each timed state through its full count with a mix of deselect, no-op and burst stop, and samples on the exact edge where the state should change. A counter that is off by one would show up as early or late exits. Every forbidden command is sent once into auto-precharge recovery, which catches a legality table that lets write or read through as it would in plain recovery, or that sends the bank to row active instead of precharge. Burst stop is sent into both refresh and mode-register access, which catches a table that treats the two states alike. Commands for other banks, commands after a low clock enable, and all-bank refresh or precharge are mixed in, so a design that ignores the bank filter, the one-cycle enable lag, or the all-bank exceptions would show false flags or false transitions.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_BST   = 4'd2,
        CMD_RD    = 4'd3,
        CMD_WR    = 4'd4,
        CMD_ACT   = 4'd5,
        CMD_PRE   = 4'd6,
        CMD_REF   = 4'd7,
        CMD_MRS   = 4'd8
    } cmd_e;

    typedef enum logic [2:0] {
        BK_IDLE    = 3'd0,
        BK_ACTIVE  = 3'd1,
        BK_WREC    = 3'd2,
        BK_WREC_AP = 3'd3,
        BK_PRECH   = 3'd4,
        BK_REFRESH = 3'd5,
        BK_MODE    = 3'd6
    } bank_st_e;

    typedef struct packed {
        logic sel_n;
        logic row_n;
        logic col_n;
        logic wr_n;
    } ctl_pins_t;

    // Legality of a command in a given bank state; untracked states accept all.
    function automatic logic cmd_legal(bank_st_e st, cmd_e c);
        case (st)
            BK_WREC:    return c inside {CMD_DESEL, CMD_NOP, CMD_BST, CMD_RD, CMD_WR};
            BK_WREC_AP: return c inside {CMD_DESEL, CMD_NOP, CMD_BST};
            BK_REFRESH: return c inside {CMD_DESEL, CMD_NOP, CMD_BST};
            BK_MODE:    return c inside {CMD_DESEL, CMD_NOP};
            default:    return 1'b1;
        endcase
    endfunction

    // Commands that reach every bank regardless of bank address.
    function automatic logic cmd_all_bank(cmd_e c, logic a10);
        return (c == CMD_REF) || (c == CMD_MRS) || ((c == CMD_PRE) && a10);
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_chk_pkg::*;
(
    input  ctl_pins_t pins,
    output cmd_e      cmd
);
    always_comb begin
        if (pins.sel_n) begin
            cmd = CMD_DESEL;
        end else begin
            case ({pins.row_n, pins.col_n, pins.wr_n})
                3'b111:  cmd = CMD_NOP;
                3'b110:  cmd = CMD_BST;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b011:  cmd = CMD_ACT;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                default: cmd = CMD_MRS;
            endcase
        end
    end
endmodule

// File: rtl/sdram_state_timer.sv
module sdram_state_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdram_bank_checker.sv
module sdram_bank_checker
    import sdram_chk_pkg::*;
#(
    parameter int BA_W    = 2,
    parameter int BANK_ID = 0,
    parameter int T_DPL   = 2,
    parameter int T_RC    = 7,
    parameter int T_RSC   = 2,
    parameter int T_RP    = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] ba,
    input  logic            a10,
    input  logic            cke,
    output logic [2:0]      state_o,
    output logic            illegal_o,
    output logic [3:0]      cmd_o
);
    localparam int T_M1  = (T_DPL > T_RC) ? T_DPL : T_RC;
    localparam int T_M2  = (T_RSC > T_RP) ? T_RSC : T_RP;
    localparam int T_MAX = (T_M1 > T_M2) ? T_M1 : T_M2;
    localparam int CNT_W = (T_MAX < 2) ? 1 : $clog2(T_MAX);
    localparam logic [CNT_W-1:0] LD_DPL = CNT_W'(T_DPL - 1);
    localparam logic [CNT_W-1:0] LD_RC  = CNT_W'(T_RC - 1);
    localparam logic [CNT_W-1:0] LD_RSC = CNT_W'(T_RSC - 1);
    localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
    localparam logic [BA_W-1:0]  MY_BA  = BA_W'(BANK_ID);

    ctl_pins_t        pins;
    cmd_e             cmd_c;
    bank_st_e         st_q, st_d;
    logic             cke_q;
    logic             illegal_q;
    cmd_e             cmd_q;
    logic             applies_c, legal_c, ill_c, moved_c;
    logic             tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_val;

    assign pins = '{sel_n: cs_n, row_n: ras_n, col_n: cas_n, wr_n: we_n};

    sdram_cmd_decode u_dec (
        .pins (pins),
        .cmd  (cmd_c)
    );

    sdram_state_timer #(.W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero_o   (tmr_zero)
    );

    assign applies_c = cke_q && ((ba == MY_BA) || cmd_all_bank(cmd_c, a10));
    assign legal_c   = cmd_legal(st_q, cmd_c);
    assign ill_c     = applies_c && !legal_c;

    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        moved_c  = 1'b0;
        if (applies_c && legal_c) begin
            case (st_q)
                BK_IDLE: begin
                    case (cmd_c)
                        CMD_ACT: begin st_d = BK_ACTIVE; moved_c = 1'b1; end
                        CMD_REF: begin st_d = BK_REFRESH; tmr_load = 1'b1; tmr_val = LD_RC; moved_c = 1'b1; end
                        CMD_MRS: begin st_d = BK_MODE; tmr_load = 1'b1; tmr_val = LD_RSC; moved_c = 1'b1; end
                        default: ;
                    endcase
                end
                BK_ACTIVE, BK_WREC: begin
                    case (cmd_c)
                        CMD_WR: begin
                            st_d     = a10 ? BK_WREC_AP : BK_WREC;
                            tmr_load = 1'b1;
                            tmr_val  = LD_DPL;
                            moved_c  = 1'b1;
                        end
                        CMD_PRE: begin
                            if (st_q == BK_ACTIVE) begin
                                st_d = BK_PRECH; tmr_load = 1'b1; tmr_val = LD_RP; moved_c = 1'b1;
                            end
                        end
                        CMD_RD: begin
                            if (st_q == BK_WREC) begin
                                moved_c = 1'b1;
                                if (a10) begin
                                    st_d = BK_PRECH; tmr_load = 1'b1; tmr_val = LD_RP;
                                end else begin
                                    st_d = BK_ACTIVE;
                                end
                            end
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
        if (!moved_c && tmr_zero) begin
            case (st_q)
                BK_WREC:    st_d = BK_ACTIVE;
                BK_WREC_AP: begin st_d = BK_PRECH; tmr_load = 1'b1; tmr_val = LD_RP; end
                BK_PRECH, BK_REFRESH, BK_MODE: st_d = BK_IDLE;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= BK_IDLE;
            cke_q     <= 1'b1;
            illegal_q <= 1'b0;
            cmd_q     <= CMD_DESEL;
        end else begin
            st_q      <= st_d;
            cke_q     <= cke;
            illegal_q <= ill_c;
            cmd_q     <= cmd_c;
        end
    end

    assign state_o   = st_q;
    assign illegal_o = illegal_q;
    assign cmd_o     = cmd_q;

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (st_q == BK_IDLE) && !illegal_q); // R10
    AST_ILLEGAL_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
        (ill_c && !tmr_zero) |=> $stable(st_q)); // R9
    AST_CKE_LOW_SILENT: assert property (@(posedge clk) disable iff (rst)
        !cke_q |=> !illegal_q); // R7
    AST_REFRESH_EXIT: assert property (@(posedge clk) disable iff (rst)
        (st_q == BK_REFRESH && tmr_zero) |=> (st_q == BK_IDLE)); // R5
    AST_AUTOPRE_EXIT: assert property (@(posedge clk) disable iff (rst)
        (st_q == BK_WREC_AP && tmr_zero) |=> (st_q == BK_PRECH)); // R4
    AST_MODE_BST_FLAG: assert property (@(posedge clk) disable iff (rst)
        (st_q == BK_MODE && applies_c && cmd_c == CMD_BST) |=> illegal_q); // R6
endmodule

// File: tb/sdram_bank_checker_tb.sv
`timescale 1ns/1ps
module sdram_bank_checker_tb;
    localparam int TDPL = 2, TRC = 4, TRSC = 2, TRP = 2;
    localparam int S_IDLE = 0, S_ACT = 1, S_WREC = 2, S_WRAP = 3, S_PRE = 4, S_REF = 5, S_MODE = 6;
    localparam int C_DES = 0, C_NOP = 1, C_BST = 2, C_RD = 3, C_WR = 4, C_ACT = 5, C_PRE = 6, C_REF = 7, C_MRS = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0;
    logic a10 = 1'b0;
    logic cke = 1'b1;
    logic [2:0] state_o;
    logic illegal_o;
    logic [3:0] cmd_o;
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sdram_bank_checker #(.BA_W(2), .BANK_ID(0), .T_DPL(TDPL), .T_RC(TRC),
                         .T_RSC(TRSC), .T_RP(TRP)) u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .a10(a10), .cke(cke), .state_o(state_o), .illegal_o(illegal_o), .cmd_o(cmd_o)
    );

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(int c, int b = 0, bit a = 1'b0);
        @(negedge clk);
        case (c)
            C_DES:   {cs_n, ras_n, cas_n, we_n} = 4'b1111;
            C_NOP:   {cs_n, ras_n, cas_n, we_n} = 4'b0111;
            C_BST:   {cs_n, ras_n, cas_n, we_n} = 4'b0110;
            C_RD:    {cs_n, ras_n, cas_n, we_n} = 4'b0101;
            C_WR:    {cs_n, ras_n, cas_n, we_n} = 4'b0100;
            C_ACT:   {cs_n, ras_n, cas_n, we_n} = 4'b0011;
            C_PRE:   {cs_n, ras_n, cas_n, we_n} = 4'b0010;
            C_REF:   {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            default: {cs_n, ras_n, cas_n, we_n} = 4'b0000;
        endcase
        ba  = 2'(b);
        a10 = a;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_st(string req, int st, int ill);
        check(req, "state", int'(state_o), st);
        check(req, "illegal", int'(illegal_o), ill);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        expect_st("R10", S_IDLE, 0);
    endtask

    task automatic t_decode();
        cke = 1'b0;
        drive(C_DES);
        for (int c = 0; c <= 8; c++) begin
            drive(c);
            check("R1", "cmd code", int'(cmd_o), c);
            expect_st("R7", S_IDLE, 0);
        end
        cke = 1'b1;
        drive(C_DES);
    endtask

    task automatic t_cke();
        drive(C_ACT);            expect_st("R11", S_ACT, 0);
        cke = 1'b0; drive(C_NOP);
        cke = 1'b1; drive(C_PRE); expect_st("R7", S_ACT, 0);
        drive(C_PRE);            expect_st("R11", S_PRE, 0);
        drive(C_DES);            expect_st("R11", S_PRE, 0);
        drive(C_DES);            expect_st("R11", S_IDLE, 0);
        drive(C_REF);            expect_st("R11", S_REF, 0);
        cke = 1'b0; drive(C_NOP);
        cke = 1'b1; drive(C_ACT); expect_st("R7", S_REF, 0);
        drive(C_ACT);            expect_st("R5", S_REF, 1);
        drive(C_DES);            expect_st("R5", S_IDLE, 0);
    endtask

    task automatic t_wrrec();
        drive(C_ACT);            expect_st("R11", S_ACT, 0);
        drive(C_WR);             expect_st("R11", S_WREC, 0);
        drive(C_NOP);            expect_st("R2", S_WREC, 0);
        drive(C_BST);            expect_st("R2", S_ACT, 0);
        drive(C_WR);             expect_st("R2", S_WREC, 0);
        drive(C_DES);            expect_st("R2", S_WREC, 0);
        drive(C_DES);            expect_st("R2", S_ACT, 0);
        drive(C_WR);  drive(C_ACT); expect_st("R3", S_WREC, 1);
        drive(C_WR);             expect_st("R9", S_WREC, 0);
        drive(C_PRE);            expect_st("R3", S_WREC, 1);
        check("R9", "cmd with flag", int'(cmd_o), C_PRE);
        drive(C_WR);  drive(C_REF); expect_st("R3", S_WREC, 1);
        drive(C_WR);  drive(C_MRS); expect_st("R3", S_WREC, 1);
        drive(C_RD);             expect_st("R3", S_ACT, 0);
        drive(C_WR);  drive(C_WR, 0, 1'b1); expect_st("R3", S_WRAP, 0);
        drive(C_NOP);            expect_st("R4", S_WRAP, 0);
        drive(C_NOP);            expect_st("R4", S_PRE, 0);
        drive(C_DES); drive(C_DES); expect_st("R11", S_IDLE, 0);
        drive(C_ACT); drive(C_WR); drive(C_RD, 0, 1'b1); expect_st("R3", S_PRE, 0);
        drive(C_DES); drive(C_DES); expect_st("R11", S_IDLE, 0);
    endtask

    task automatic t_wrap();
        int bad [6] = '{C_RD, C_WR, C_ACT, C_PRE, C_REF, C_MRS};
        foreach (bad[i]) begin
            drive(C_ACT);
            drive(C_WR, 0, 1'b1); expect_st("R11", S_WRAP, 0);
            drive(bad[i]);        expect_st("R4", S_WRAP, 1);
            drive(C_NOP);         expect_st("R4", S_PRE, 0);
            drive(C_DES); drive(C_DES); expect_st("R11", S_IDLE, 0);
        end
        drive(C_ACT); drive(C_WR, 0, 1'b1);
        drive(C_BST);            expect_st("R4", S_WRAP, 0);
        drive(C_DES);            expect_st("R4", S_PRE, 0);
        drive(C_DES); drive(C_DES); expect_st("R11", S_IDLE, 0);
    endtask

    task automatic t_refresh();
        drive(C_REF);            expect_st("R11", S_REF, 0);
        drive(C_BST);            expect_st("R5", S_REF, 0);
        drive(C_NOP);            expect_st("R5", S_REF, 0);
        drive(C_DES);            expect_st("R5", S_REF, 0);
        drive(C_NOP);            expect_st("R5", S_IDLE, 0);
        drive(C_REF);
        drive(C_RD);             expect_st("R5", S_REF, 1);
        drive(C_MRS);            expect_st("R5", S_REF, 1);
        check("R9", "cmd with flag", int'(cmd_o), C_MRS);
        drive(C_ACT);            expect_st("R5", S_REF, 1);
        drive(C_DES);            expect_st("R5", S_IDLE, 0);
    endtask

    task automatic t_mode();
        drive(C_MRS);            expect_st("R11", S_MODE, 0);
        drive(C_BST);            expect_st("R6", S_MODE, 1);
        drive(C_NOP);            expect_st("R6", S_IDLE, 0);
        drive(C_MRS);
        drive(C_NOP);            expect_st("R6", S_MODE, 0);
        drive(C_DES);            expect_st("R6", S_IDLE, 0);
        drive(C_MRS);
        drive(C_WR);             expect_st("R6", S_MODE, 1);
        drive(C_DES);            expect_st("R6", S_IDLE, 0);
    endtask

    task automatic t_bank();
        drive(C_ACT, 1);         expect_st("R8", S_IDLE, 0);
        drive(C_ACT, 0);         expect_st("R8", S_ACT, 0);
        drive(C_WR, 1);          expect_st("R8", S_ACT, 0);
        drive(C_WR, 0);          expect_st("R8", S_WREC, 0);
        drive(C_ACT, 1);         expect_st("R8", S_WREC, 0);
        drive(C_WR, 0);
        drive(C_PRE, 1, 1'b1);   expect_st("R8", S_WREC, 1);
        drive(C_WR, 0);
        drive(C_PRE, 1, 1'b0);   expect_st("R8", S_WREC, 0);
        drive(C_WR, 0);
        drive(C_REF, 2);         expect_st("R8", S_WREC, 1);
        drive(C_RD, 0, 1'b1);    expect_st("R8", S_PRE, 0);
        drive(C_DES); drive(C_DES); expect_st("R11", S_IDLE, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_decode();
        t_cke();
        t_wrrec();
        t_wrap();
        t_refresh();
        t_mode();
        t_bank();
        drive(C_DES); drive(C_DES);
        rst = 1'b1;
        drive(C_DES);
        rst = 1'b0;
        expect_st("R10", S_IDLE, 0);
        finish_run();
    end

    initial begin
        #(200000 * 8);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule